// File: doc/BRIEF.md
# Hybrid Prefix / Carry-Select Ling Adder

This block is a purely combinational 32-bit binary adder. It returns the 32-bit sum of two unsigned operands and the carry out of the top bit. There is no carry-in and no register stage, so a change at the inputs reaches the outputs in the same time step.

Internally it works on Ling pseudo-carries instead of true carries. Each bit forms a generate, a transmit and a half-sum. The pseudo-carries for even bit positions and for odd bit positions are built on two separate chains. A Kogge-Stone prefix scan evaluates each chain, but only at the boundaries between 4-bit slices.

Inside each 4-bit slice, two candidate results are formed in parallel: one assumes an incoming pseudo-carry of 0 and one assumes 1. The real boundary pseudo-carry then picks a candidate through a multiplexer. Because a pseudo-carry is not a real carry, each candidate rebuilds the real carry by ANDing the pseudo-carry with the transmit of the bit below. The even-position sum bits of a slice are chosen by the odd chain. The odd-position sum bits are chosen by the even chain.

Top module: `ling_hybrid_adder`

## Requirements
- R1: `sum_o` equals the low 32 bits of the unsigned sum `a_op + b_op` for every operand pair.
- R2: `cout_o` equals bit 32 of the 33-bit unsigned sum `a_op + b_op`.
- R3: With both operands zero, `sum_o` is 0 and `cout_o` is 0.
- R4: With both operands all ones, `sum_o` is 0xFFFF_FFFE and `cout_o` is 1.
- R5: `cout_o` is 1 whenever bit 31 of both operands is 1, and 0 whenever bit 31 of both operands is 0.
- R6: A carry generated in bit 0 and propagated through every higher bit clears the sum, sets `cout_o`, and so crosses all seven slice boundaries (for example 0xFFFF_FFFF + 1 gives sum 0 and carry 1).
- R7: A carry generated in the top bit of one 4-bit slice (bit 4k-1, k = 1..7), or rippled up to it from bit 0, appears at bit 4k of the next slice and at no other bit.
- R8: When one operand is zero, `sum_o` equals the other operand and `cout_o` is 0.
- R9: For single-bit operands `1<<i` and `1<<j`, the result has exactly the bits of the arithmetic sum. Equal positions move the bit to i+1, or to the carry when i is 31.
- R10: The outputs follow the inputs with no clock, within the same time step as the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 32 | First addend |
| b_op | input | 32 | Second addend |
| sum_o | output | 32 | Low 32 bits of the sum |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
The bench targets carries that have to cross a 4-bit slice boundary, either generated in the slice's top bit or rippled from bit 0. A design that selects a slice's result on the raw pseudo-carry, without ANDing in the transmit of the bit below, adds a spurious one at the next slice's lowest bit. A design that swaps the even and odd chains, or feeds a slice the boundary of the wrong slice, corrupts every other sum bit in the affected slice. The all-ones, all-zero and full-ripple operands show a carry-out that has been dropped or inverted. Single-bit pairs over every position, together with random operands, catch a candidate built with the wrong assumed pseudo-carry.

// File: rtl/ling_hybrid_adder.sv
module ling_hybrid_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_op,
  input  logic [W-1:0] b_op,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NB = W / 4;

  logic [W-1:0] g, t, p, gs, ts;
  logic [NB-1:0] odd_g, odd_t, evn_g, evn_t;
  logic [NB-1:0] h_odd, h_evn;

  assign g  = a_op & b_op;
  assign t  = a_op | b_op;
  assign p  = a_op ^ b_op;
  // two-step Ling terms: H_i = gs_i | ts_i & H_(i-2)
  assign gs = g | {g[W-2:0], 1'b0};
  assign ts = {t[W-2:0], 1'b0} & {t[W-3:0], 2'b0};

  function automatic logic [NB-1:0] ks_scan(input logic [NB-1:0] gi, input logic [NB-1:0] ti);
    logic [NB-1:0] gc, tc, gn, tn;
    gc = gi;
    tc = ti;
    for (int d = 1; d < NB; d = d * 2) begin
      gn = gc;
      tn = tc;
      for (int j = d; j < NB; j++) begin
        gn[j] = gc[j] | (tc[j] & gc[j-d]);
        tn[j] = tc[j] & tc[j-d];
      end
      gc = gn;
      tc = tn;
    end
    return gc;
  endfunction

  // odd block j spans positions 4j+1, 4j+3 -> H(4j+3)
  // even block j spans positions 4j-4, 4j-2 -> H(4j-2), block 0 is empty
  for (genvar j = 0; j < NB; j++) begin : g_blk
    assign odd_g[j] = gs[4*j+3] | (ts[4*j+3] & gs[4*j+1]);
    assign odd_t[j] = ts[4*j+3] & ts[4*j+1];
    if (j == 0) begin : g_first
      assign evn_g[j] = 1'b0;
      assign evn_t[j] = 1'b0;
    end else begin : g_rest
      assign evn_g[j] = gs[4*j-2] | (ts[4*j-2] & gs[4*j-4]);
      assign evn_t[j] = ts[4*j-2] & ts[4*j-4];
    end
  end

  assign h_odd = ks_scan(odd_g, odd_t);
  assign h_evn = ks_scan(evn_g, evn_t);

  for (genvar k = 0; k < NB; k++) begin : g_sel
    localparam int B = 4 * k;
    logic ho_in, t_below;
    logic h1_0, h1_1, h0_0, h0_1, h2_0, h2_1;
    logic [1:0] ev0, ev1, od0, od1, ev, od;

    if (k == 0) begin : g_lsb
      assign ho_in   = 1'b0;
      assign t_below = 1'b0;
    end else begin : g_mid
      assign ho_in   = h_odd[k-1];
      assign t_below = t[B-1];
    end

    // even positions B, B+2 hang on the odd chain
    assign h1_0 = gs[B+1];
    assign h1_1 = gs[B+1] | ts[B+1];
    assign ev0  = {p[B+2] ^ (t[B+1] & h1_0), p[B]};
    assign ev1  = {p[B+2] ^ (t[B+1] & h1_1), p[B] ^ t_below};

    // odd positions B+1, B+3 hang on the even chain
    assign h0_0 = gs[B];
    assign h0_1 = gs[B] | ts[B];
    assign h2_0 = gs[B+2] | (ts[B+2] & h0_0);
    assign h2_1 = gs[B+2] | (ts[B+2] & h0_1);
    assign od0  = {p[B+3] ^ (t[B+2] & h2_0), p[B+1] ^ (t[B] & h0_0)};
    assign od1  = {p[B+3] ^ (t[B+2] & h2_1), p[B+1] ^ (t[B] & h0_1)};

    assign ev = ho_in    ? ev1 : ev0;
    assign od = h_evn[k] ? od1 : od0;

    assign sum_o[B+3:B] = {od[1], ev[1], od[0], ev[0]};
  end

  assign cout_o = t[W-1] & h_odd[NB-1];

endmodule

// File: rtl/ling_hybrid_adder_chk.sv
module ling_hybrid_adder_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_op,
  input logic [W-1:0] b_op,
  input logic [W-1:0] sum_o,
  input logic         cout_o
);
  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, a_op} + {1'b0, b_op};

  always_comb begin
    p_sum_low_r1: assert (sum_o == ref_sum[W-1:0])
      else $error("sum mismatch");
    p_carry_out_r2: assert (cout_o == ref_sum[W])
      else $error("carry mismatch");
    p_msb_generate_r5: assert (!(a_op[W-1] && b_op[W-1]) || cout_o)
      else $error("carry missing with both MSBs set");
    p_msb_kill_r5: assert (a_op[W-1] || b_op[W-1] || !cout_o)
      else $error("carry with both MSBs clear");
    p_zero_operand_r8: assert (b_op != '0 || (sum_o == a_op && !cout_o))
      else $error("zero operand changed result");
    p_zero_pair_r3: assert (a_op != '0 || b_op != '0 || (sum_o == '0 && !cout_o))
      else $error("nonzero result from zero operands");
  end
endmodule

bind ling_hybrid_adder ling_hybrid_adder_chk #(.W(W)) i_chk (
  .a_op(a_op), .b_op(b_op), .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/test_ling_hybrid_adder.sv
`timescale 1ns/1ps
module test_ling_hybrid_adder;
  logic        clk = 1'b0;
  logic [31:0] a_op = '0, b_op = '0;
  logic [31:0] sum_o;
  logic        cout_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ling_hybrid_adder i_ling_hybrid_adder (
    .a_op(a_op), .b_op(b_op), .sum_o(sum_o), .cout_o(cout_o)
  );

  task automatic check(input logic [31:0] x, input logic [31:0] y, input string req);
    logic [32:0] exp_v;
    @(negedge clk);
    a_op = x;
    b_op = y;
    #1;
    exp_v = {1'b0, x} + {1'b0, y};
    n_run++;
    if ({cout_o, sum_o} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h got cout=%b sum=%h expected cout=%b sum=%h",
               req, x, y, cout_o, sum_o, exp_v[32], exp_v[31:0]);
    end
  endtask

  task automatic t_zero();
    check(32'h0, 32'h0, "R3 zero operands");
  endtask

  task automatic t_all_ones();
    check(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 all ones");
  endtask

  task automatic t_full_ripple();
    check(32'hFFFF_FFFF, 32'h1, "R6 ripple from bit 0");
    check(32'h1, 32'hFFFF_FFFF, "R6 ripple swapped");
    check(32'h7FFF_FFFF, 32'h1, "R6 ripple to MSB");
    check(32'hAAAA_AAAA, 32'h5555_5556, "R6 alternating ripple");
  endtask

  task automatic t_group_edges();
    for (int k = 1; k < 8; k++) begin
      check(32'h1 << (4*k-1), 32'h1 << (4*k-1), "R7 generate at slice top");
      check((32'h1 << (4*k)) - 1, 32'h1, "R7 ripple into next slice");
      check(32'h1 << (4*k-1), (32'h1 << (4*k-1)) | (32'h1 << (4*k)), "R7 carry meets set bit");
    end
  endtask

  task automatic t_msb();
    check(32'h8000_0000, 32'h8000_0000, "R5 both MSBs set");
    check(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 both MSBs clear");
    check(32'h8000_0000, 32'h7FFF_FFFF, "R5 one MSB no carry");
  endtask

  task automatic t_zero_identity();
    check(32'hDEAD_BEEF, 32'h0, "R8 zero b");
    check(32'h0, 32'h1234_5678, "R8 zero a");
    check(32'hFFFF_FFFF, 32'h0, "R8 ones plus zero");
  endtask

  task automatic t_single_bits();
    for (int i = 0; i < 32; i++) begin
      check(32'h1 << i, 32'h1 << i, "R9 equal single bits");
      check(32'h1 << i, 32'h1 << (31 - i), "R9 mirrored single bits");
      check(32'h1 << i, 32'h1, "R9 bit plus one");
    end
  endtask

  task automatic t_random();
    logic [31:0] s = 32'h1D87_2B41;
    logic [31:0] x;
    for (int n = 0; n < 3000; n++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      x = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      check(x, s, "R1 R2 random");
    end
  endtask

  task automatic t_no_clock();
    // R10: outputs settle without any clock edge
    logic [32:0] exp_v;
    @(negedge clk);
    #1;
    a_op = 32'h0F0F_0F0F;
    b_op = 32'h00F0_00F1;
    #1;
    exp_v = {1'b0, a_op} + {1'b0, b_op};
    n_run++;
    if ({cout_o, sum_o} !== exp_v) begin
      n_fail++;
      $display("FAIL R10 same step: got %b_%h expected %b_%h",
               cout_o, sum_o, exp_v[32], exp_v[31:0]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_zero();
    t_all_ones();
    t_full_ripple();
    t_group_edges();
    t_msb();
    t_zero_identity();
    t_single_bits();
    t_no_clock();
    t_random();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule